// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a chain of scan cells that sits between a core and its pads. Every core input and core output runs through one cell, and every core output also has its own cell that holds the output enable. Each cell has two stages. The first stage can capture a value and shift it. The second stage only changes on an update strobe and holds a value that can be applied. The capture, shift and update strobes, the test clock and a two-bit mode come from an external test port controller. The chain has one serial input and one serial output.

With the mode at functional or sample, the cells are transparent. Pins connect straight to the core, while the chain may still capture and shift live values. In external test, the pads are driven from the held test values. In internal test, the core inputs are driven from held test values and the pad drivers are switched off. Values loaded during sample stay in the update stage, so they reach the pins as soon as external test is selected.

Top module: `bscan_chain`

## Requirements
- R1: An active-low reset (`trst_n`) clears both stages of every cell. After reset, the first L bits shifted out are all zero.
- R2: With mode 2'b00 (functional) or 2'b01 (sample), `core_in` equals `pin_in`, `pin_out` equals `core_out`, and `pin_oe` equals `core_oe`.
- R3: A rising `tck` edge with `cap_en` high loads the chain as follows: bits [NI-1:0] from `pin_in`, bits [NI+NO-1:NI] from `core_out`, and bits [NI+2*NO-1:NI+NO] from `core_oe`. Here L = NI+2*NO.
- R4: A rising `tck` edge with `shift_en` high (and `cap_en` low) moves every bit one place toward bit 0 and loads `sin` into bit L-1. `sout` always shows bit 0.
- R5: The update stage copies the whole chain on a rising `tck` edge with `upd_en` high. At every other edge it holds, including during capture and shift.
- R6: With mode 2'b10 (external test), `pin_out` takes the output-data cells of the update stage and `pin_oe` takes the control cells. `core_in` still follows `pin_in`.
- R7: Values placed in the update stage while in sample mode appear on `pin_out` and `pin_oe` in the same cycle that the mode changes to external test, with no further strobe.
- R8: With mode 2'b11 (internal test), `core_in` takes the input cells of the update stage, `pin_out` takes the output-data cells, and `pin_oe` is forced to 0.
- R9: In sample mode, capture, shift and update activity leaves `core_in`, `pin_out` and `pin_oe` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset |
| mode | input | 2 | 00 functional, 01 sample, 10 external test, 11 internal test |
| cap_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| sin | input | 1 | Serial data into bit L-1 |
| sout | output | 1 | Serial data from bit 0 |
| pin_in | input | NI | Values arriving at input pads |
| core_in | output | NI | Values delivered to the core |
| core_out | input | NO | Core output data |
| core_oe | input | NO | Core output enables |
| pin_out | output | NO | Data to output pads |
| pin_oe | output | NO | Enables to output pads |

## Verification
The checker assumes that the test port controller raises at most one of `cap_en`, `shift_en` and `upd_en` at a time. It flags any overlap as a violation of that contract. It also assumes the mode changes only between scan operations. The bench drives every strobe and mode change on the falling edge and pulses exactly one strobe per cycle, so it stays inside both assumptions.

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int NI = 4,
  parameter int NO = 4
) (
  input  logic          tck,
  input  logic          trst_n,
  input  logic [1:0]    mode,
  input  logic          cap_en,
  input  logic          shift_en,
  input  logic          upd_en,
  input  logic          sin,
  output logic          sout,
  input  logic [NI-1:0] pin_in,
  output logic [NI-1:0] core_in,
  input  logic [NO-1:0] core_out,
  input  logic [NO-1:0] core_oe,
  output logic [NO-1:0] pin_out,
  output logic [NO-1:0] pin_oe
);
  localparam int L      = NI + 2*NO;
  localparam int DO_LO  = NI;
  localparam int CT_LO  = NI + NO;
  localparam logic [1:0] M_EXT = 2'b10;
  localparam logic [1:0] M_INT = 2'b11;

  logic [L-1:0] chain, upd;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)       chain <= '0;
    else if (cap_en)   chain <= {core_oe, core_out, pin_in};
    else if (shift_en) chain <= {sin, chain[L-1:1]};

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)     upd <= '0;
    else if (upd_en) upd <= chain;

  assign sout    = chain[0];
  assign core_in = (mode == M_INT) ? upd[NI-1:0] : pin_in;

  always_comb begin
    unique case (mode)
      M_EXT: begin
        pin_out = upd[DO_LO +: NO];
        pin_oe  = upd[CT_LO +: NO];
      end
      M_INT: begin
        pin_out = upd[DO_LO +: NO];
        pin_oe  = '0;
      end
      default: begin
        pin_out = core_out;
        pin_oe  = core_oe;
      end
    endcase
  end
endmodule

// File: rtl/bscan_chain_checker.sv
module bscan_chain_checker #(
  parameter int NI = 4,
  parameter int NO = 4,
  parameter int L  = NI + 2*NO
) (
  input logic          tck,
  input logic          trst_n,
  input logic [1:0]    mode,
  input logic          cap_en,
  input logic          shift_en,
  input logic          upd_en,
  input logic          sin,
  input logic          sout,
  input logic [NI-1:0] pin_in,
  input logic [NI-1:0] core_in,
  input logic [NO-1:0] core_out,
  input logic [NO-1:0] core_oe,
  input logic [NO-1:0] pin_out,
  input logic [NO-1:0] pin_oe,
  input logic [L-1:0]  chain,
  input logic [L-1:0]  upd
);
  assert_strobes_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
    $countones({cap_en, shift_en, upd_en}) <= 1);

  assert_functional_pass_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (mode[1] == 1'b0) |-> (core_in == pin_in && pin_out == core_out && pin_oe == core_oe));

  assert_capture_inputs_R3: assert property (@(posedge tck) disable iff (!trst_n)
    cap_en |=> (chain == {$past(core_oe), $past(core_out), $past(pin_in)}));

  assert_shift_step_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_en && !cap_en) |=> (sout == $past(chain[1]) && chain[L-1] == $past(sin)));

  assert_update_hold_R5: assert property (@(posedge tck) disable iff (!trst_n)
    !upd_en |=> $stable(upd));

  assert_update_copy_R5: assert property (@(posedge tck) disable iff (!trst_n)
    upd_en |=> (upd == $past(chain)));

  assert_extest_drive_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == 2'b10) |-> (pin_oe == upd[NI+NO +: NO] && pin_out == upd[NI +: NO]));

  assert_intest_quiet_R8: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == 2'b11) |-> (pin_oe == '0 && core_in == upd[NI-1:0]));
endmodule

bind bscan_chain bscan_chain_checker #(.NI(NI), .NO(NO)) u_chk (
  .tck(tck), .trst_n(trst_n), .mode(mode), .cap_en(cap_en), .shift_en(shift_en),
  .upd_en(upd_en), .sin(sin), .sout(sout), .pin_in(pin_in), .core_in(core_in),
  .core_out(core_out), .core_oe(core_oe), .pin_out(pin_out), .pin_oe(pin_oe),
  .chain(chain), .upd(upd)
);

// File: tb/bscan_chain_test.sv
module bscan_chain_test;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int L  = NI + 2*NO;

  logic tck = 1'b0, trst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic cap_en = 0, shift_en = 0, upd_en = 0, sin = 0, sout;
  logic [NI-1:0] pin_in = '0, core_in;
  logic [NO-1:0] core_out = '0, core_oe = '0, pin_out, pin_oe;

  int tests = 0, fails = 0;
  logic done = 1'b0;

  always #4 tck = ~tck;

  bscan_chain #(.NI(NI), .NO(NO)) uut (
    .tck(tck), .trst_n(trst_n), .mode(mode), .cap_en(cap_en), .shift_en(shift_en),
    .upd_en(upd_en), .sin(sin), .sout(sout), .pin_in(pin_in), .core_in(core_in),
    .core_out(core_out), .core_oe(core_oe), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // mode, pin_in, core_out, core_oe, exp core_in, exp pin_out, exp pin_oe
  typedef logic [25:0] vec_t;
  localparam vec_t VECS [8] = '{
    {2'b00, 4'hA, 4'h5, 4'hF, 4'hA, 4'h5, 4'hF},
    {2'b00, 4'h3, 4'hC, 4'h1, 4'h3, 4'hC, 4'h1},
    {2'b01, 4'h7, 4'h8, 4'h6, 4'h7, 4'h8, 4'h6},
    {2'b01, 4'h0, 4'hF, 4'h0, 4'h0, 4'hF, 4'h0},
    {2'b10, 4'h9, 4'h6, 4'hF, 4'h9, 4'h0, 4'h0},
    {2'b10, 4'hE, 4'h1, 4'hA, 4'hE, 4'h0, 4'h0},
    {2'b11, 4'h5, 4'hA, 4'hF, 4'h0, 4'h0, 4'h0},
    {2'b11, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_cap();
    @(negedge tck) cap_en = 1'b1;
    @(negedge tck) cap_en = 1'b0;
  endtask

  task automatic pulse_upd();
    @(negedge tck) upd_en = 1'b1;
    @(negedge tck) upd_en = 1'b0;
  endtask

  task automatic scan(input logic [L-1:0] din, output logic [L-1:0] dout);
    for (int i = 0; i < L; i++) begin
      @(negedge tck);
      dout[i] = sout;
      sin = din[i];
      shift_en = 1'b1;
    end
    @(negedge tck) shift_en = 1'b0;
    sin = 1'b0;
  endtask

  logic [L-1:0] got;

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #3;
    check("R1 sout in reset", {31'd0, sout}, 32'd0);
    repeat (3) @(negedge tck);
    trst_n = 1'b1;

    for (int k = 0; k < 8; k++) begin
      @(negedge tck);
      {mode, pin_in, core_out, core_oe} = VECS[k][25:12];
      #1;
      check("R2/R6/R8 table core_in", {28'd0, core_in}, {28'd0, VECS[k][11:8]});
      check("R2/R6/R8 table pin_out", {28'd0, pin_out}, {28'd0, VECS[k][7:4]});
      check("R2/R6/R8 table pin_oe",  {28'd0, pin_oe},  {28'd0, VECS[k][3:0]});
    end

    @(negedge tck) mode = 2'b00;
    scan(12'h000, got);
    check("R1 chain clear after reset", {20'd0, got}, 32'd0);

    @(negedge tck);
    mode = 2'b01; pin_in = 4'hA; core_out = 4'h5; core_oe = 4'hC;
    pulse_cap();
    check("R9 sample capture keeps pins", {24'd0, pin_out, pin_oe}, {24'd0, 4'h5, 4'hC});
    scan(12'h396, got);
    check("R3 capture then R4 shift order", {20'd0, got}, {20'd0, 12'hC5A});
    check("R9 sample shift keeps core_in", {28'd0, core_in}, {28'd0, 4'hA});
    pulse_upd();
    check("R9 sample update keeps pins", {24'd0, pin_out, pin_oe}, {24'd0, 4'h5, 4'hC});

    @(negedge tck) mode = 2'b10;
    #1;
    check("R7 preload visible on extest", {24'd0, pin_out, pin_oe}, {24'd0, 4'h9, 4'h3});
    check("R6 extest core_in follows pin", {28'd0, core_in}, {28'd0, 4'hA});

    scan(12'hFFF, got);
    check("R4 chain retained after update", {20'd0, got}, {20'd0, 12'h396});
    check("R5 update holds during shift", {24'd0, pin_out, pin_oe}, {24'd0, 4'h9, 4'h3});
    pulse_cap();
    check("R5 update holds during capture", {24'd0, pin_out, pin_oe}, {24'd0, 4'h9, 4'h3});
    scan(12'hFFF, got);
    check("R3 extest capture of pins", {20'd0, got}, {20'd0, 12'hC5A});
    pulse_upd();
    check("R5 update copies chain", {24'd0, pin_out, pin_oe}, {24'd0, 8'hFF});

    scan(12'h0C3, got);
    pulse_upd();
    @(negedge tck) mode = 2'b11; pin_in = 4'h6;
    #1;
    check("R8 intest core_in from cells", {28'd0, core_in}, {28'd0, 4'h3});
    check("R8 intest pin_oe off", {28'd0, pin_oe}, 32'd0);
    check("R8 intest pin_out from cells", {28'd0, pin_out}, {28'd0, 4'hC});

    @(negedge tck) trst_n = 1'b0;
    #1;
    check("R1 reset clears update stage", {28'd0, core_in}, 32'd0);
    @(negedge tck) trst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule